// File: doc/BRIEF.md
# Cascade Parallel Transfer Ring Node

This block is the inter-chip exchange logic of one node in a cascade of echo-canceller chips. One node runs in master role and up to six run in slave role; they share a 16-bit parallel bus on which intermediate results pass from node to node. Ownership of the bus travels around a ring of active-low strobes. The master starts a round. Each node, when it receives the token, drives its own word for a fixed slot. It then pulses its outgoing strobe, which hands the token on. The downstream node latches the bus on that strobe's falling edge. The master also broadcasts its strobe to every slave, so all slaves latch the master's word at the same moment.

The role comes from a mode input. A master with its ring output wired back to its own ring input forms a single-chip loopback, in which the master receives its own word. The bus itself is modelled as a data output, an output enable and a data input. A released bus (enable low) stands for high impedance. All strobes are assumed to be synchronous to the shared master clock.

Top module: `cxr_node`

## Requirements
- R1: While `rst_n` or `pdn_n` is low, `bus_oe` is 0, `bus_out` is 0 and both `ring_out_n` and `bcast_out_n` are 1. Dropping `pdn_n` in the middle of a slot releases the bus at once. After release the node is idle and drives nothing until a new token or start arrives.
- R2: In master role (`slave_mode`=0), a high `start` sampled by a clock edge while the node is idle opens a slot from that edge. `start` has no effect while a slot is running, and it has no effect at all in slave role.
- R3: A slot holds `bus_oe` high for exactly 2 clock cycles. `ring_out_n` is low for exactly one cycle, the second driven cycle, and the bus is released on the following edge. `bus_out` is 0 whenever `bus_oe` is 0.
- R4: The word driven during a slot is the value of `tx_word` at the edge that opened the slot. It stays unchanged for the whole slot even if `tx_word` changes.
- R5: On an edge where `ring_in_n` is 0 and was 1 at the previous edge, the node stores `bus_in` in `rx_chain` and raises `rx_chain_vld` for exactly one cycle. Holding `ring_in_n` low for longer produces no further capture.
- R6: In slave role, a falling `ring_in_n` also opens the node's own slot on the same edge. In master role, `ring_in_n` only captures and never opens a slot.
- R7: In master role, `bcast_out_n` pulses low together with `ring_out_n`. In slave role, `bcast_out_n` stays 1. A slave stores `bus_in` in `rx_bcast` and pulses `rx_bcast_vld` on a falling `bcast_in_n`. A master ignores `bcast_in_n`.
- R8: In loopback, a master whose `ring_out_n` feeds its own `ring_in_n` presents its own word on `rx_chain`, with `rx_chain_vld` high, in the cycle after the third edge counted from the edge that sampled `start`.
- R9: In a ring of one master and two slaves, at most one node has `bus_oe` high in any cycle. Slot k begins two cycles after slot k-1 begins, and the master receives the last slave's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdn_n | input | 1 | Power-down, active low |
| slave_mode | input | 1 | Role: 0 master or single chip, 1 slave |
| start | input | 1 | Round start request, used in master role only |
| tx_word | input | 16 | Word this node sends in its slot |
| bus_in | input | 16 | Resolved value of the shared bus |
| bus_out | output | 16 | Value this node drives onto the bus |
| bus_oe | output | 1 | Bus drive enable, 0 means released |
| ring_out_n | output | 1 | Token strobe to the next node, active low |
| bcast_out_n | output | 1 | Broadcast strobe to all slaves, active low |
| ring_in_n | input | 1 | Token strobe from the previous node, active low |
| bcast_in_n | input | 1 | Broadcast strobe from the master, active low |
| rx_chain | output | 16 | Word captured on the ring strobe |
| rx_chain_vld | output | 1 | One-cycle pulse on a ring capture |
| rx_bcast | output | 16 | Word captured on the broadcast strobe |
| rx_bcast_vld | output | 1 | One-cycle pulse on a broadcast capture |

## Verification
The hardest situations to reach from a single node's ports are bus contention and the behaviour of a token strobe held low for longer than one cycle. In a correctly wired ring, the strobe pulse is always exactly one cycle long and nodes follow each other strictly. The bench therefore wires one master and two slaves onto a resolved bus and watches the count of enables in every cycle. A bench-side override on the first slave's ring input can hold that strobe low for several cycles, and a loopback select closes the master on itself. Power-down is dropped in the middle of a slot to show the bus released at once and no leftover strobe after release.

// File: rtl/cxr_pkg.sv
package cxr_pkg;

  typedef enum logic [0:0] {
    SLOT_IDLE  = 1'b0,
    SLOT_DRIVE = 1'b1
  } slot_st_e;

  // Active-low strobe went from released to asserted between two samples.
  function automatic logic strobe_fell(input logic prev_n, input logic now_n);
    return prev_n & ~now_n;
  endfunction

  // Is this beat the last one of a slot lasting hold beats?
  function automatic logic is_last_beat(input int unsigned beat, input int unsigned hold);
    return beat == (hold - 1);
  endfunction

endpackage

// File: rtl/cxr_fall_det.sv
module cxr_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn_n,
  input  logic strobe_n,
  output logic fell
);
  import cxr_pkg::*;

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= 1'b1;
    else if (!pdn_n) prev_q <= 1'b1;
    else             prev_q <= strobe_n;
  end

  assign fell = pdn_n & strobe_fell(prev_q, strobe_n);

endmodule

// File: rtl/cxr_slot_fsm.sv
module cxr_slot_fsm #(
  parameter int DATA_W   = 16,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn_n,
  input  logic              launch,
  input  logic [DATA_W-1:0] word_in,
  output logic              drive_en,
  output logic              flag_low,
  output logic [DATA_W-1:0] word_out
);
  import cxr_pkg::*;

  localparam int BEAT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  slot_st_e          st_q;
  logic [BEAT_W-1:0] beat_q;
  logic [DATA_W-1:0] word_q;
  logic              last_beat;

  assign last_beat = is_last_beat({{(32-BEAT_W){1'b0}}, beat_q}, HOLD_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SLOT_IDLE;
      beat_q <= '0;
      word_q <= '0;
    end else if (!pdn_n) begin
      st_q   <= SLOT_IDLE;
      beat_q <= '0;
    end else begin
      case (st_q)
        SLOT_IDLE: begin
          if (launch) begin
            st_q   <= SLOT_DRIVE;
            beat_q <= '0;
            word_q <= word_in;
          end
        end
        default: begin
          if (last_beat) begin
            st_q   <= SLOT_IDLE;
            beat_q <= '0;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign drive_en = (st_q == SLOT_DRIVE);
  assign flag_low = drive_en & last_beat;
  assign word_out = word_q;

  // a launch arriving during a running slot leaves the held word untouched
  AST_BUSY_LAUNCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n || !pdn_n)
    (drive_en && launch) |=> $stable(word_out)); // R2

endmodule

// File: rtl/cxr_rx_reg.sv
module cxr_rx_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn_n,
  input  logic              take,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] word,
  output logic              vld
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      vld  <= 1'b0;
    end else if (!pdn_n) begin
      vld  <= 1'b0;
    end else begin
      vld <= take;
      if (take) word <= data_in;
    end
  end

  AST_RX_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n || !pdn_n)
    vld |=> !vld); // R5

endmodule

// File: rtl/cxr_node.sv
module cxr_node #(
  parameter int DATA_W   = 16,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn_n,
  input  logic              slave_mode,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              ring_out_n,
  output logic              bcast_out_n,
  input  logic              ring_in_n,
  input  logic              bcast_in_n,
  output logic [DATA_W-1:0] rx_chain,
  output logic              rx_chain_vld,
  output logic [DATA_W-1:0] rx_bcast,
  output logic              rx_bcast_vld
);

  // named internal events
  logic              ev_ring_fell;
  logic              ev_bcast_fell;
  logic              ev_bcast_take;
  logic              ev_launch;
  logic              alive;
  logic              slot_drive;
  logic              slot_flag;
  logic [DATA_W-1:0] slot_word;

  assign alive = rst_n & pdn_n;

  cxr_fall_det u_ring_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .pdn_n    (pdn_n),
    .strobe_n (ring_in_n),
    .fell     (ev_ring_fell)
  );

  cxr_fall_det u_bcast_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .pdn_n    (pdn_n),
    .strobe_n (bcast_in_n),
    .fell     (ev_bcast_fell)
  );

  assign ev_bcast_take = slave_mode & ev_bcast_fell;
  assign ev_launch     = slave_mode ? ev_ring_fell : start;

  cxr_slot_fsm #(
    .DATA_W   (DATA_W),
    .HOLD_CYC (HOLD_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pdn_n    (pdn_n),
    .launch   (ev_launch),
    .word_in  (tx_word),
    .drive_en (slot_drive),
    .flag_low (slot_flag),
    .word_out (slot_word)
  );

  cxr_rx_reg #(.DATA_W(DATA_W)) u_rx_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .pdn_n   (pdn_n),
    .take    (ev_ring_fell),
    .data_in (bus_in),
    .word    (rx_chain),
    .vld     (rx_chain_vld)
  );

  cxr_rx_reg #(.DATA_W(DATA_W)) u_rx_bcast (
    .clk     (clk),
    .rst_n   (rst_n),
    .pdn_n   (pdn_n),
    .take    (ev_bcast_take),
    .data_in (bus_in),
    .word    (rx_bcast),
    .vld     (rx_bcast_vld)
  );

  assign bus_oe      = alive & slot_drive;
  assign bus_out     = bus_oe ? slot_word : '0;
  assign ring_out_n  = ~(alive & slot_flag);
  assign bcast_out_n = ~(alive & slot_flag & ~slave_mode);

  always_comb begin
    if (!(rst_n && pdn_n)) begin
      AST_QUIET_WHEN_DOWN: assert (!bus_oe && ring_out_n && bcast_out_n && (bus_out == '0)); // R1
    end
  end

  AST_FLAG_INSIDE_SLOT: assert property (@(posedge clk) disable iff (!rst_n || !pdn_n)
    !ring_out_n |-> bus_oe); // R3
  AST_FLAG_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n || !pdn_n)
    !ring_out_n |-> $past(bus_oe)); // R3
  AST_RELEASE_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n || !pdn_n)
    !ring_out_n |=> (!bus_oe && ring_out_n)); // R3
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n || !pdn_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_out)); // R4
  AST_SLAVE_NO_BCAST: assert property (@(posedge clk) disable iff (!rst_n || !pdn_n)
    slave_mode |-> bcast_out_n); // R7
  AST_MASTER_NO_BCAST_RX: assert property (@(posedge clk) disable iff (!rst_n || !pdn_n)
    ($past(!slave_mode) && $past(slave_mode) == slave_mode) |-> !rx_bcast_vld); // R7

endmodule

// File: tb/tb_cxr_node.sv
`timescale 1ns/1ps
module tb_cxr_node;

  localparam int CLK_NS = 8;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int checks   = 0;
  int failures = 0;

  logic rst_n = 1'b0;
  logic pdn_n = 1'b1;
  logic loop_sel = 1'b0;
  logic s1_ovr = 1'b0;
  logic tb_s1_ring = 1'b1;
  logic tb_m_bcast = 1'b1;

  logic        m_start = 1'b0, s1_start = 1'b0, s2_start = 1'b0;
  logic [15:0] m_tx = '0, s1_tx = '0, s2_tx = '0;

  logic [15:0] bus;
  logic [15:0] m_out, s1_out, s2_out;
  logic        m_oe, s1_oe, s2_oe;
  logic        m_ring_out, s1_ring_out, s2_ring_out;
  logic        m_bc_out, s1_bc_out, s2_bc_out;
  logic        m_ring_in, s1_ring_in, s2_ring_in;
  logic [15:0] m_rxc, s1_rxc, s2_rxc, m_rxb, s1_rxb, s2_rxb;
  logic        m_cv, s1_cv, s2_cv, m_bv, s1_bv, s2_bv;

  assign bus = (m_oe ? m_out : 16'h0) | (s1_oe ? s1_out : 16'h0) | (s2_oe ? s2_out : 16'h0);
  assign m_ring_in  = loop_sel ? m_ring_out : s2_ring_out;
  assign s1_ring_in = s1_ovr ? tb_s1_ring : (loop_sel ? 1'b1 : m_ring_out);
  assign s2_ring_in = s1_ring_out;

  cxr_node dut (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .slave_mode(1'b0), .start(m_start),
    .tx_word(m_tx), .bus_in(bus), .bus_out(m_out), .bus_oe(m_oe),
    .ring_out_n(m_ring_out), .bcast_out_n(m_bc_out), .ring_in_n(m_ring_in),
    .bcast_in_n(tb_m_bcast), .rx_chain(m_rxc), .rx_chain_vld(m_cv),
    .rx_bcast(m_rxb), .rx_bcast_vld(m_bv));

  cxr_node u_sl1 (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .slave_mode(1'b1), .start(s1_start),
    .tx_word(s1_tx), .bus_in(bus), .bus_out(s1_out), .bus_oe(s1_oe),
    .ring_out_n(s1_ring_out), .bcast_out_n(s1_bc_out), .ring_in_n(s1_ring_in),
    .bcast_in_n(m_bc_out), .rx_chain(s1_rxc), .rx_chain_vld(s1_cv),
    .rx_bcast(s1_rxb), .rx_bcast_vld(s1_bv));

  cxr_node u_sl2 (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .slave_mode(1'b1), .start(s2_start),
    .tx_word(s2_tx), .bus_in(bus), .bus_out(s2_out), .bus_oe(s2_oe),
    .ring_out_n(s2_ring_out), .bcast_out_n(s2_bc_out), .ring_in_n(s2_ring_in),
    .bcast_in_n(m_bc_out), .rx_chain(s2_rxc), .rx_chain_vld(s2_cv),
    .rx_bcast(s2_rxb), .rx_bcast_vld(s2_bv));

  // contention monitor for R9
  logic overlap = 1'b0;
  always @(negedge clk) begin
    if (rst_n && ((int'(m_oe) + int'(s1_oe) + int'(s2_oe)) > 1)) overlap = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle_cycles(3);
    chk(m_oe == 1'b0,       "R1 reset oe",    32'(m_oe), 0);
    chk(m_out == 16'h0,     "R1 reset bus",   32'(m_out), 0);
    chk(m_ring_out == 1'b1, "R1 reset ring",  32'(m_ring_out), 1);
    chk(m_bc_out == 1'b1,   "R1 reset bcast", 32'(m_bc_out), 1);
    chk(s1_oe == 1'b0 && s1_ring_out == 1'b1, "R1 reset slave", {s1_oe, s1_ring_out}, 32'h1);
    rst_n = 1'b1;
    idle_cycles(2);
  endtask

  // single-chip loopback; start_len cycles of start, tx changed after launch
  task automatic t_loopback(input logic [15:0] w, input int start_len);
    loop_sel = 1'b1;
    @(negedge clk);
    m_tx = w;
    m_start = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i == 0) m_tx = ~w;
      if (i == start_len - 1) m_start = 1'b0;
      chk(m_oe == (i < 2), "R3 slot enable", 32'(m_oe), 32'(i < 2));
      chk(m_ring_out == !(i == 1), "R3 ring strobe", 32'(m_ring_out), 32'(!(i == 1)));
      chk(m_bc_out == !(i == 1), "R7 master bcast strobe", 32'(m_bc_out), 32'(!(i == 1)));
      if (i < 2) chk(m_out == w, "R4 held word", 32'(m_out), 32'(w));
      else       chk(m_out == 16'h0, "R3 released bus value", 32'(m_out), 0);
      chk(m_cv == (i == 2), "R8 loopback valid", 32'(m_cv), 32'(i == 2));
      if (i == 2) chk(m_rxc == w, "R8 loopback word", 32'(m_rxc), 32'(w));
    end
    loop_sel = 1'b0;
    idle_cycles(2);
  endtask

  task automatic t_slave_start;
    loop_sel = 1'b1;
    @(negedge clk);
    s1_start = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      s1_start = 1'b0;
      chk(s1_oe == 1'b0 && s1_ring_out == 1'b1, "R2 slave ignores start", {s1_oe, s1_ring_out}, 32'h1);
    end
    loop_sel = 1'b0;
  endtask

  task automatic t_ring;
    overlap = 1'b0;
    loop_sel = 1'b0;
    @(negedge clk);
    m_tx = 16'h1111; s1_tx = 16'h2222; s2_tx = 16'h3333;
    m_start = 1'b1;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      m_start = 1'b0;
      chk(m_oe  == (i < 2),           "R9 master slot", 32'(m_oe), 32'(i < 2));
      chk(s1_oe == (i == 2 || i == 3), "R6 slave1 slot", 32'(s1_oe), 32'(i == 2 || i == 3));
      chk(s2_oe == (i == 4 || i == 5), "R9 slave2 slot", 32'(s2_oe), 32'(i == 4 || i == 5));
      chk(s1_bc_out && s2_bc_out, "R7 slave bcast quiet", {s1_bc_out, s2_bc_out}, 32'h3);
      chk(s1_bv == (i == 2) && s2_bv == (i == 2), "R7 slave bcast valid", {s1_bv, s2_bv}, (i == 2) ? 32'h3 : 32'h0);
      if (i == 2) begin
        chk(s1_rxb == 16'h1111 && s2_rxb == 16'h1111, "R7 bcast word", {s1_rxb, s2_rxb}, 32'h11111111);
        chk(s1_cv && s1_rxc == 16'h1111, "R5 slave1 chain capture", {15'h0, s1_cv, s1_rxc}, 32'h11111);
      end
      chk(s2_cv == (i == 4), "R5 slave2 chain valid", 32'(s2_cv), 32'(i == 4));
      if (i == 4) chk(s2_rxc == 16'h2222, "R5 slave2 chain word", 32'(s2_rxc), 32'h2222);
      chk(m_cv == (i == 6), "R9 master return valid", 32'(m_cv), 32'(i == 6));
      if (i == 6) chk(m_rxc == 16'h3333, "R9 master return word", 32'(m_rxc), 32'h3333);
      if (i >= 6) chk(m_oe == 1'b0, "R6 master no slot on return", 32'(m_oe), 0);
    end
    chk(overlap == 1'b0, "R9 single driver", 32'(overlap), 0);
  endtask

  task automatic t_held_token;
    int vld_n = 0;
    int oe_n  = 0;
    loop_sel = 1'b0;
    s1_ovr = 1'b1;
    tb_s1_ring = 1'b1;
    idle_cycles(2);
    tb_s1_ring = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (s1_cv) vld_n++;
      if (s1_oe) oe_n++;
      if (i == 0) chk(s1_cv == 1'b1, "R5 capture on first low", 32'(s1_cv), 1);
    end
    chk(vld_n == 1, "R5 held low captures once", 32'(vld_n), 1);
    chk(oe_n == 2,  "R6 held low one slot", 32'(oe_n), 2);
    tb_s1_ring = 1'b1;
    s1_ovr = 1'b0;
    idle_cycles(8);
  endtask

  task automatic t_master_bcast;
    tb_m_bcast = 1'b1;
    @(negedge clk);
    tb_m_bcast = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(m_bv == 1'b0 && m_oe == 1'b0, "R7 master ignores bcast in", {m_bv, m_oe}, 0);
    end
    tb_m_bcast = 1'b1;
    idle_cycles(2);
  endtask

  task automatic t_powerdown;
    loop_sel = 1'b1;
    @(negedge clk);
    m_tx = 16'hBEEF;
    m_start = 1'b1;
    @(negedge clk);
    m_start = 1'b0;
    chk(m_oe == 1'b1, "R2 slot opened", 32'(m_oe), 1);
    pdn_n = 1'b0;
    #1;
    chk(m_oe == 1'b0 && m_out == 16'h0, "R1 power-down releases bus", {m_oe, m_out}, 0);
    chk(m_ring_out && m_bc_out, "R1 power-down strobes high", {m_ring_out, m_bc_out}, 32'h3);
    idle_cycles(2);
    pdn_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(m_oe == 1'b0 && m_cv == 1'b0 && m_ring_out == 1'b1, "R1 idle after power-down",
          {m_oe, m_cv, m_ring_out}, 32'h1);
    end
    loop_sel = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_loopback(16'hA5C3, 1);
    t_loopback(16'h0001, 2);   // second start cycle lands in a busy slot (R2)
    t_slave_start();
    t_ring();
    t_held_token();
    t_master_bcast();
    t_powerdown();
    t_loopback(16'h7E81, 1);   // recovery after power-down
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule